// File: doc/BRIEF.md
# Multi-Format Signed Adder-Subtractor

This block adds or subtracts two W-bit signed operands without any clock. A two-bit format code tells it how to read both operands and how to encode the result. The choices are two's complement, one's complement and sign-magnitude. A one-bit operation input selects the sum or the difference A − B. The result comes back in the same format as the operands, together with an overflow flag.

In both complement formats, one carry-lookahead adder built from per-bit generate and propagate terms does the arithmetic. A subtraction inverts the second operand. Two's complement also injects a carry of one. One's complement feeds the carry out of the top bit back into the bottom bit through a second adder pass.

Sign-magnitude operands take a different route through the same adder. The block first flips the sign of B when subtracting, which gives B's effective sign. When A's sign and B's effective sign are equal, the magnitudes are added. When they differ, the larger magnitude is chosen and the smaller one is taken from it. A small control module works out these decisions and hands them to the datapath as a struct of strobes. A parameter chooses between a lookahead carry network and a rippled one.

Top module: `asu_top`

## Requirements
- R1: Format code 0 (two's complement), add: `result` = (opA + opB) mod 2^W. Any carry out of the top bit is dropped.
- R2: Format code 0, subtract (`subOp`=1): `result` = opA + ~opB + 1, taken mod 2^W.
- R3: Complement formats: `overflow` is 1 exactly when the two adder inputs (opA, and opB or ~opB) have equal top bits and the top bit of the final sum differs from them.
- R4: Format code 1 (one's complement), add: form opA + opB. If that sum carries out of bit W-1, add the carry back into bit 0.
- R5: Format code 1, subtract: form opA + ~opB with no injected one. The same end-around carry rule as in R4 then applies.
- R6: Format code 2 (sign-magnitude: bit W-1 is the sign, 1 = negative; bits W-2..0 are the magnitude). When A's sign equals B's effective sign (B's sign bit XOR `subOp`), the magnitudes are added and that common sign is kept. `overflow` is 1 when the magnitude sum exceeds 2^(W-1)-1; in that case the low W-1 bits of the sum are returned.
- R7: Format code 2 with A's sign different from B's effective sign: the smaller magnitude is taken from the larger one. The result carries the sign of the larger-magnitude operand; when the magnitudes are equal, A counts as the larger. `overflow` is 0.
- R8: Format code 2: a result whose magnitude field is zero always has sign bit 0.
- R9: Format code 3 behaves exactly like format code 0.
- R10: The outputs follow the inputs in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fmtSel | input | 2 | Operand format: 0 two's complement, 1 one's complement, 2 sign-magnitude, 3 same as 0 |
| subOp | input | 1 | 0 = opA + opB, 1 = opA − opB |
| opA | input | W | First operand |
| opB | input | W | Second operand |
| result | output | W | Sum or difference, in the selected format |
| overflow | output | 1 | Result does not fit in the selected format |

## Verification
The immediate assertions are evaluated whenever any input changes. They check four things:
- the adder's sum and carry match plain integer addition;
- the one's complement wrap-around pass never carries out again;
- the sign-magnitude subtract path always finds the larger magnitude first;
- the two's complement result matches a modular sum or difference, a zero sign-magnitude result is positive, and magnitude subtraction never raises overflow.

Some behaviours only the bench's scenarios can show, because they need values worked out by hand. These are:
- where the end-around carry lands in one's complement;
- which operand's sign wins when the magnitudes differ;
- the wrapped magnitude returned on a sign-magnitude overflow;
- that format code 3 matches code 0.

// File: rtl/asu_pkg.sv
package asu_pkg;

  // Operand/result encodings chosen by the format select input
  typedef enum logic [1:0] {
    FMT_TWOS = 2'b00,
    FMT_ONES = 2'b01,
    FMT_SMAG = 2'b10,
    FMT_ALT  = 2'b11
  } numFmt_e;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic selMag;     // route magnitudes instead of whole words
    logic swapOps;    // put opB's magnitude on the x side
    logic magSub;     // sign-magnitude operands have different effective signs
    logic invertY;    // invert the y adder input
    logic carryIn;    // carry injected into bit 0
    logic endAround;  // fold carry-out back into bit 0
    logic resSign;    // sign bit for a sign-magnitude result
  } strobe_t;

endpackage

// File: rtl/asu_adder.sv
module asu_adder #(
  parameter int W = 8,
  parameter bit USE_LOOKAHEAD = 1'b1
) (
  input  logic [W-1:0] xIn,
  input  logic [W-1:0] yIn,
  input  logic         cIn,
  output logic [W-1:0] sum,
  output logic         cOut
);

  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W-1:0] cNext;   // carry out of each bit position
  logic [W:0]   carry;

  assign gen   = xIn & yIn;
  assign prop  = xIn ^ yIn;
  assign carry = {cNext, cIn};
  assign sum   = prop ^ carry[W-1:0];
  assign cOut  = carry[W];

  generate
    if (USE_LOOKAHEAD) begin : g_lookahead
      // Each carry is a flat OR of generate terms, each qualified by the propagates above it
      always_comb begin
        logic acc;
        logic term;
        for (int i = 0; i < W; i++) begin
          acc = 1'b0;
          for (int j = 0; j <= i + 1; j++) begin
            if (j == 0) term = cIn;
            else        term = gen[j-1];
            for (int k = j; k <= i; k++) term = term & prop[k];
            acc = acc | term;
          end
          cNext[i] = acc;
        end
      end
    end else begin : g_ripple
      always_comb begin
        logic c;
        c = cIn;
        for (int i = 0; i < W; i++) begin
          cNext[i] = gen[i] | (prop[i] & c);
          c = cNext[i];
        end
      end
    end
  endgenerate

  always_comb begin
    // R1
    adder_sum_chk: assert ({cOut, sum} == ({1'b0, xIn} + {1'b0, yIn} + {{W{1'b0}}, cIn}))
      else $error("adder sum/carry differs from integer addition");
  end

endmodule

// File: rtl/asu_ctrl.sv
module asu_ctrl
  import asu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   fmtSel,
  input  logic         subOp,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output strobe_t      strobes
);

  localparam int MW = W - 1;

  logic [MW-1:0] magA;
  logic [MW-1:0] magB;
  logic          signA;
  logic          signBEff;
  logic          aSmaller;

  assign magA     = opA[MW-1:0];
  assign magB     = opB[MW-1:0];
  assign signA    = opA[W-1];
  assign signBEff = opB[W-1] ^ subOp;
  assign aSmaller = magA < magB;

  always_comb begin
    strobes = '0;
    unique case (numFmt_e'(fmtSel))
      FMT_ONES: begin
        strobes.invertY   = subOp;
        strobes.endAround = 1'b1;
      end
      FMT_SMAG: begin
        strobes.selMag  = 1'b1;
        strobes.magSub  = signA ^ signBEff;
        strobes.swapOps = strobes.magSub & aSmaller;
        strobes.invertY = strobes.magSub;
        strobes.carryIn = strobes.magSub;
        strobes.resSign = strobes.swapOps ? signBEff : signA;
      end
      default: begin
        strobes.invertY = subOp;
        strobes.carryIn = subOp;
      end
    endcase
  end

endmodule

// File: rtl/asu_datapath.sv
module asu_datapath
  import asu_pkg::*;
#(
  parameter int W = 8,
  parameter bit USE_LOOKAHEAD = 1'b1
) (
  input  strobe_t      strobes,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] result,
  output logic         overflow
);

  localparam int MW = W - 1;

  logic [W-1:0] xIn;
  logic [W-1:0] yBase;
  logic [W-1:0] yIn;
  logic [W-1:0] rawSum;
  logic         rawCout;
  logic [W-1:0] fixedSum;
  logic         wrapCout;
  logic         magZero;
  logic         ovfComp;
  logic         ovfMag;

  // Operand routing: full words, or magnitudes zero-extended into W bits
  always_comb begin
    if (strobes.selMag) begin
      xIn   = {1'b0, strobes.swapOps ? opB[MW-1:0] : opA[MW-1:0]};
      yBase = {1'b0, strobes.swapOps ? opA[MW-1:0] : opB[MW-1:0]};
    end else begin
      xIn   = opA;
      yBase = opB;
    end
  end

  assign yIn = strobes.invertY ? ~yBase : yBase;

  asu_adder #(.W(W), .USE_LOOKAHEAD(USE_LOOKAHEAD)) u_main (
    .xIn  (xIn),
    .yIn  (yIn),
    .cIn  (strobes.carryIn),
    .sum  (rawSum),
    .cOut (rawCout)
  );

  // End-around pass: adds the main carry back in for one's complement
  asu_adder #(.W(W), .USE_LOOKAHEAD(USE_LOOKAHEAD)) u_wrap (
    .xIn  (rawSum),
    .yIn  ({W{1'b0}}),
    .cIn  (strobes.endAround & rawCout),
    .sum  (fixedSum),
    .cOut (wrapCout)
  );

  assign magZero  = ~|fixedSum[MW-1:0];
  assign ovfComp  = (xIn[W-1] == yIn[W-1]) && (fixedSum[W-1] != xIn[W-1]);
  assign ovfMag   = ~strobes.magSub & rawSum[W-1];

  always_comb begin
    if (strobes.selMag) begin
      result   = {strobes.resSign & ~magZero, fixedSum[MW-1:0]};
      overflow = ovfMag;
    end else begin
      result   = fixedSum;
      overflow = ovfComp;
    end
  end

  always_comb begin
    // R7
    mag_order_chk: assert (!(strobes.selMag && strobes.magSub) || rawCout)
      else $error("magnitude subtraction borrowed: smaller operand on x side");
    // R4
    ones_wrap_chk: assert (!wrapCout)
      else $error("end-around carry pass carried out again");
  end

endmodule

// File: rtl/asu_top.sv
module asu_top
  import asu_pkg::*;
#(
  parameter int W = 8,
  parameter bit USE_LOOKAHEAD = 1'b1
) (
  input  logic [1:0]   fmtSel,
  input  logic         subOp,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] result,
  output logic         overflow
);

  strobe_t strobes;

  asu_ctrl #(.W(W)) u_ctrl (
    .fmtSel  (fmtSel),
    .subOp   (subOp),
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes)
  );

  asu_datapath #(.W(W), .USE_LOOKAHEAD(USE_LOOKAHEAD)) u_dp (
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .overflow (overflow)
  );

  logic isComp2;
  logic isSmag;
  logic smDiffSign;

  assign isComp2    = (fmtSel == FMT_TWOS) || (fmtSel == FMT_ALT);
  assign isSmag     = (fmtSel == FMT_SMAG);
  assign smDiffSign = opA[W-1] ^ opB[W-1] ^ subOp;

  always_comb begin
    // R1
    twos_sum_chk: assert (!isComp2 || (result == (subOp ? opA - opB : opA + opB)))
      else $error("two's complement result is not the modular sum/difference");
    // R8
    sm_zero_sign_chk: assert (!isSmag || (|result[W-2:0]) || !result[W-1])
      else $error("sign-magnitude zero result carries a negative sign");
    // R7
    sm_no_ovf_chk: assert (!(isSmag && smDiffSign) || !overflow)
      else $error("overflow raised on sign-magnitude magnitude subtraction");
  end

endmodule

// File: tb/tb_asu_top.sv
module tb_asu_top;

  localparam int W = 8;

  logic         clk;
  logic         rstN;
  logic [1:0]   fmtSel;
  logic         subOp;
  logic [W-1:0] opA;
  logic [W-1:0] opB;
  logic [W-1:0] result;
  logic         overflow;

  int  nCompared = 0;
  int  nMismatch = 0;
  bit  finished  = 1'b0;

  asu_top #(.W(W)) dut (
    .fmtSel   (fmtSel),
    .subOp    (subOp),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .overflow (overflow)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic runCase(input logic [1:0] f, input logic s,
                         input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] expR, input logic expO,
                         input string tag);
    @(negedge clk);
    fmtSel = f;
    subOp  = s;
    opA    = a;
    opB    = b;
    #1;
    nCompared++;
    if (result !== expR || overflow !== expO) begin
      nMismatch++;
      $display("FAIL %s: fmt=%0d sub=%0b a=%h b=%h actual result=%h ovf=%b expected result=%h ovf=%b",
               tag, f, s, a, b, result, overflow, expR, expO);
    end
  endtask

  // Reference built from the requirement text
  function automatic void model(input logic [1:0] f, input logic s,
                                input logic [W-1:0] a, input logic [W-1:0] b,
                                output logic [W-1:0] r, output logic o);
    logic [W-1:0] bb;
    logic [W:0]   t;
    int maxMag, va, vb, sm, mg, rm;
    logic [W-2:0] rmBits;
    bb = s ? ~b : b;
    if (f == 2'd1) begin
      t = {1'b0, a} + {1'b0, bb};
      r = t[W-1:0] + {{(W-1){1'b0}}, t[W]};
      o = (a[W-1] == bb[W-1]) && (r[W-1] != a[W-1]);
    end else if (f == 2'd2) begin
      maxMag = (1 << (W - 1)) - 1;
      va = int'(a[W-2:0]);
      vb = int'(b[W-2:0]);
      if (a[W-1]) va = -va;
      if (b[W-1] ^ s) vb = -vb;
      sm = va + vb;
      mg = (sm < 0) ? -sm : sm;
      o = mg > maxMag;
      rm = mg % (maxMag + 1);
      rmBits = rm[W-2:0];
      r = {(sm < 0) && (rm != 0), rmBits};
    end else begin
      t = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, s};
      r = t[W-1:0];
      o = (a[W-1] == bb[W-1]) && (r[W-1] != a[W-1]);
    end
  endfunction

  task automatic testReset();
    runCase(2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, "R10 idle zero");
    runCase(2'd2, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, "R10 idle zero sm");
  endtask

  task automatic testTwosAdd();
    runCase(2'd0, 1'b0, 8'hF9, 8'h04, 8'hFD, 1'b0, "R1 -7+4");
    runCase(2'd0, 1'b0, 8'hFF, 8'h01, 8'h00, 1'b0, "R1 carry dropped");
    runCase(2'd0, 1'b0, 8'h7F, 8'h01, 8'h80, 1'b1, "R3 positive overflow");
    runCase(2'd0, 1'b0, 8'h80, 8'hFF, 8'h7F, 1'b1, "R3 negative overflow");
  endtask

  task automatic testTwosSub();
    runCase(2'd0, 1'b1, 8'h02, 8'h07, 8'hFB, 1'b0, "R2 2-7");
    runCase(2'd0, 1'b1, 8'h07, 8'hF9, 8'h0E, 1'b0, "R2 7-(-7)");
    runCase(2'd0, 1'b1, 8'h80, 8'h01, 8'h7F, 1'b1, "R3 subtract overflow");
  endtask

  task automatic testOnesAdd();
    runCase(2'd1, 1'b0, 8'hEC, 8'h12, 8'hFE, 1'b0, "R4 -19+18 no carry");
    runCase(2'd1, 1'b0, 8'hFC, 8'h12, 8'h0F, 1'b0, "R4 end-around carry");
    runCase(2'd1, 1'b0, 8'h7F, 8'h01, 8'h80, 1'b1, "R3 ones overflow");
  endtask

  task automatic testOnesSub();
    runCase(2'd1, 1'b1, 8'h05, 8'h03, 8'h02, 1'b0, "R5 5-3");
    runCase(2'd1, 1'b1, 8'h03, 8'h05, 8'hFD, 1'b0, "R5 3-5");
  endtask

  task automatic testSmagSame();
    runCase(2'd2, 1'b0, 8'h85, 8'h83, 8'h88, 1'b0, "R6 -5+-3");
    runCase(2'd2, 1'b0, 8'hC5, 8'hC5, 8'h8A, 1'b1, "R6 wrapped overflow");
    runCase(2'd2, 1'b1, 8'h60, 8'hA0, 8'h00, 1'b1, "R6 96-(-32) overflow");
  endtask

  task automatic testSmagDiff();
    runCase(2'd2, 1'b0, 8'h12, 8'h93, 8'h81, 1'b0, "R7 18+-19");
    runCase(2'd2, 1'b1, 8'h13, 8'h05, 8'h0E, 1'b0, "R7 19-5");
    runCase(2'd2, 1'b1, 8'h85, 8'h93, 8'h0E, 1'b0, "R7 -5-(-19)");
  endtask

  task automatic testSmagZero();
    runCase(2'd2, 1'b0, 8'h25, 8'hA5, 8'h00, 1'b0, "R8 37+-37");
    runCase(2'd2, 1'b0, 8'h80, 8'h80, 8'h00, 1'b0, "R8 -0+-0");
    runCase(2'd2, 1'b1, 8'h85, 8'h85, 8'h00, 1'b0, "R8 -5-(-5)");
    runCase(2'd2, 1'b0, 8'h40, 8'h40, 8'h00, 1'b1, "R8 overflow to zero");
  endtask

  task automatic testAltFmt();
    runCase(2'd3, 1'b0, 8'h7F, 8'h01, 8'h80, 1'b1, "R9 add");
    runCase(2'd3, 1'b1, 8'h02, 8'h07, 8'hFB, 1'b0, "R9 sub");
  endtask

  task automatic testSweep();
    logic [W-1:0] er;
    logic         eo;
    string        tag;
    for (int f = 0; f < 4; f++) begin
      for (int s = 0; s < 2; s++) begin
        for (int ai = 0; ai < 256; ai += 37) begin
          for (int bi = 3; bi < 256; bi += 53) begin
            model(f[1:0], s[0], ai[W-1:0], bi[W-1:0], er, eo);
            case (f)
              0: tag = "R1 R2 R3 sweep";
              1: tag = "R4 R5 R3 sweep";
              2: tag = "R6 R7 R8 sweep";
              default: tag = "R9 sweep";
            endcase
            runCase(f[1:0], s[0], ai[W-1:0], bi[W-1:0], er, eo, tag);
          end
        end
      end
    end
  endtask

  initial begin
    fmtSel = 2'd0;
    subOp  = 1'b0;
    opA    = '0;
    opB    = '0;
    rstN   = 1'b0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testReset();
    testTwosAdd();
    testTwosSub();
    testOnesAdd();
    testOnesSub();
    testSmagSame();
    testSmagDiff();
    testSmagZero();
    testAltFmt();
    testSweep();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nMismatch++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

endmodule